// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a 32-bit virtual address into the leaf entry of a tree of translation tables held in memory. A walk begins in a per-context root table. The base of that table comes from a context table pointer input, and the current context number selects the root slot. The walk then descends through up to three levels of tables, issuing one word read per level on a simple request/response memory port. Each table entry is four bytes wide.

Table pointers are kept pre-shifted right by four bits. A pointer entry therefore has its low four bits cleared and is shifted left by four to give the physical base of the next table. A leaf can be met at any depth. A leaf at the context level covers the whole 4 GB space, a leaf at level 1 covers 16 MB, at level 2 it covers 256 KB and at level 3 it covers a 4 KB page.

The walker returns the raw leaf word and leaves interpretation to the consumer: physical page number in bits 31:8, cacheable in bit 7, modified in bit 6, referenced in bit 5 and the access field in bits 4:2. It also returns the depth code and a fault code. It runs one walk at a time. A caller starts it with a one-cycle request and waits for the single-cycle completion strobe.

Top module: `walk_unit`

## Requirements
- R1: While reset is asserted (`rstN` low, asynchronous), `busy`, `done` and `memReqValid` are low, and this includes a reset applied in the middle of a walk.
- R2: `startValid` is accepted only while `busy` is low. The cycle after acceptance `busy` and `memReqValid` are high. A `startValid` raised while `busy` is high has no effect on the addresses or the result of the walk in progress.
- R3: The first read address equals `((ctxBasePtr & 32'hFFFF_FFF0) << 4) + ctxNum*4`, truncated to 32 bits.
- R4: The entry type is bits 1:0 of a returned word (0 invalid, 1 pointer, 2 leaf, 3 reverse-order leaf). After a pointer word W at depth d (d = 0, 1 or 2), the next read is at `((W & 32'hFFFF_FFF0) << 4) + idx*4`. Here idx is vaddr[31:24] for depth 1, vaddr[23:18] for depth 2 and vaddr[17:12] for depth 3.
- R5: A leaf word of type 2 or 3 at any depth ends the walk. `resultEntry` then equals the word unchanged, `resultLevel` equals the depth (0 context, 1 to 3 table levels) and `faultCode` is 0.
- R6: A type 0 word at any depth ends the walk with `faultCode` = 1 and `resultLevel` equal to that depth.
- R7: A type 1 word at depth 3 ends the walk with `faultCode` = 2 and `resultLevel` = 3. A walk never reads more than four words.
- R8: `done` is high for exactly one cycle, in the cycle after the final response, and `busy` is low in that cycle. `busy` stays high from the cycle after acceptance up to that cycle.
- R9: `memReqValid` stays high with a stable `memReqAddr` until `memReqReady` is seen. After a request is accepted, no new request is raised before the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Begin a walk (sampled while idle) |
| startVaddr | input | 32 | Virtual address to translate |
| ctxBasePtr | input | 32 | Context table base, pre-shifted right by 4 |
| ctxNum | input | 16 | Current context number |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data word |
| done | output | 1 | One-cycle completion strobe |
| resultEntry | output | 32 | Final entry word |
| resultLevel | output | 2 | Depth where the walk ended |
| fault | output | 1 | Walk ended with a fault |
| faultCode | output | 2 | 0 none, 1 invalid entry, 2 pointer at last level |

## Verification
The assertions assume the memory side behaves correctly. `memRspValid` is raised only while a request has been accepted and its response is still outstanding, and only once per request. The context inputs are also assumed to stay steady while they are sampled at start. The bench's memory model keeps to this: it raises `memReqReady` only against a visible request, then returns exactly one word, so the request-hold and strobe properties see only legal traffic. A second start is deliberately raised during a walk, but only while the response is outstanding, so the port contract still holds.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walkState_e;

  // entry type codes in bits 1:0 of every table word
  localparam logic [1:0] ET_INVALID  = 2'd0;
  localparam logic [1:0] ET_POINTER  = 2'd1;
  localparam logic [1:0] ET_LEAF     = 2'd2;
  localparam logic [1:0] ET_LEAF_REV = 2'd3;

  // fault codes reported with done
  localparam logic [1:0] FC_NONE    = 2'd0;
  localparam logic [1:0] FC_INVALID = 2'd1;
  localparam logic [1:0] FC_DEPTH   = 2'd2;

  typedef struct packed {
    logic       capStart;  // latch vaddr and form root-slot address
    logic       advance;   // pointer word: descend one level
    logic       finish;    // capture final result
    logic [1:0] faultSel;  // fault code to capture with finish
  } walkStrobe_t;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic [1:0]  rspType,
  input  logic        atLastLevel,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memReqValid,
  output logic        done
);

  walkState_e state, stateNext;
  logic rspHere, descend;

  assign rspHere = (state == ST_WAIT) && memRspValid;
  assign descend = (rspType == ET_POINTER) && !atLastLevel;

  always_comb begin
    strobe          = '0;
    strobe.capStart = (state == ST_IDLE) && startValid;
    strobe.advance  = rspHere && descend;
    strobe.finish   = rspHere && !descend;
    unique case (rspType)
      ET_INVALID: strobe.faultSel = FC_INVALID;
      ET_POINTER: strobe.faultSel = FC_DEPTH;
      default:    strobe.faultSel = FC_NONE;
    endcase
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startValid) stateNext = ST_REQ;
      ST_REQ:  if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) stateNext = descend ? ST_REQ : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.finish;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_REQ);

  // R8: completion strobe lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: the walker is idle when it reports completion
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: a pending request is held until taken
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R9: an accepted request is not followed by another before its response
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);

endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 16,
  parameter int IDX1_W    = 8,
  parameter int IDX2_W    = 6,
  parameter int IDX3_W    = 6,
  parameter int PTR_SHIFT = 4,
  parameter int LEVEL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  startVaddr,
  input  logic [ADDR_W-1:0]  ctxBasePtr,
  input  logic [CTX_W-1:0]   ctxNum,
  input  logic [ADDR_W-1:0]  memRspData,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic               atLastLevel,
  output logic [ADDR_W-1:0]  resultEntry,
  output logic [LEVEL_W-1:0] resultLevel,
  output logic [1:0]         faultCode
);

  localparam int IDX1_LSB = ADDR_W - IDX1_W;
  localparam int IDX2_LSB = IDX1_LSB - IDX2_W;
  localparam int IDX3_LSB = IDX2_LSB - IDX3_W;
  localparam int ENTRY_SHIFT = 2;  // four bytes per entry
  localparam logic [ADDR_W-1:0] PTR_MASK = ~((ADDR_W'(1) << PTR_SHIFT) - ADDR_W'(1));
  localparam logic [LEVEL_W-1:0] LAST_LEVEL = LEVEL_W'(3);

  function automatic int lvlLsb(input int lvl);
    case (lvl)
      1:       return IDX1_LSB;
      2:       return IDX2_LSB;
      default: return IDX3_LSB;
    endcase
  endfunction

  function automatic int lvlWidth(input int lvl);
    case (lvl)
      1:       return IDX1_W;
      2:       return IDX2_W;
      default: return IDX3_W;
    endcase
  endfunction

  logic [ADDR_W-1:0]  vaddrReg;
  logic [ADDR_W-1:0]  addrReg;
  logic [LEVEL_W-1:0] levelReg;
  logic [ADDR_W-1:0]  lvlIdx [1:3];
  logic [ADDR_W-1:0]  nextIdx;
  logic [ADDR_W-1:0]  rootAddr;
  logic [ADDR_W-1:0]  childAddr;

  for (genvar g = 1; g <= 3; g++) begin : g_level_idx
    localparam int LSB = lvlLsb(g);
    localparam logic [ADDR_W-1:0] IMASK = (ADDR_W'(1) << lvlWidth(g)) - ADDR_W'(1);
    assign lvlIdx[g] = (vaddrReg >> LSB) & IMASK;
  end

  always_comb begin
    unique case (levelReg)
      LEVEL_W'(0): nextIdx = lvlIdx[1];
      LEVEL_W'(1): nextIdx = lvlIdx[2];
      default:     nextIdx = lvlIdx[3];
    endcase
  end

  assign rootAddr  = ((ctxBasePtr & PTR_MASK) << PTR_SHIFT) + (ADDR_W'(ctxNum) << ENTRY_SHIFT);
  assign childAddr = ((memRspData & PTR_MASK) << PTR_SHIFT) + (nextIdx << ENTRY_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrReg    <= '0;
      addrReg     <= '0;
      levelReg    <= '0;
      resultEntry <= '0;
      resultLevel <= '0;
      faultCode   <= FC_NONE;
    end else begin
      if (strobe.capStart) begin
        vaddrReg <= startVaddr;
        addrReg  <= rootAddr;
        levelReg <= '0;
      end
      if (strobe.advance) begin
        addrReg  <= childAddr;
        levelReg <= levelReg + LEVEL_W'(1);
      end
      if (strobe.finish) begin
        resultEntry <= memRspData;
        resultLevel <= levelReg;
        faultCode   <= strobe.faultSel;
      end
    end
  end

  assign memReqAddr  = addrReg;
  assign atLastLevel = (levelReg == LAST_LEVEL);

  // R7: the walk never descends past the last table level
  p_advance_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> levelReg != LAST_LEVEL);

endmodule

// File: rtl/walk_unit.sv
module walk_unit
  import walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startVaddr,
  input  logic [ADDR_W-1:0] ctxBasePtr,
  input  logic [CTX_W-1:0]  ctxNum,
  output logic              busy,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              done,
  output logic [ADDR_W-1:0] resultEntry,
  output logic [1:0]        resultLevel,
  output logic              fault,
  output logic [1:0]        faultCode
);

  walkStrobe_t strobe;
  logic        atLastLevel;

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspType     (memRspData[1:0]),
    .atLastLevel (atLastLevel),
    .strobe      (strobe),
    .busy        (busy),
    .memReqValid (memReqValid),
    .done        (done)
  );

  walk_dpath #(
    .ADDR_W (ADDR_W),
    .CTX_W  (CTX_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startVaddr  (startVaddr),
    .ctxBasePtr  (ctxBasePtr),
    .ctxNum      (ctxNum),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .atLastLevel (atLastLevel),
    .resultEntry (resultEntry),
    .resultLevel (resultLevel),
    .faultCode   (faultCode)
  );

  assign fault = (faultCode != FC_NONE);

  // R9: request address does not move while the request waits
  p_req_addr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  // R5: a clean finish always carries a leaf type
  p_leaf_type_r5: assert property (@(posedge clk) disable iff (!rstN)
    done && (faultCode == FC_NONE) |-> resultEntry[1]);

  // R6: an invalid-entry fault reports a type 0 word
  p_invalid_type_r6: assert property (@(posedge clk) disable iff (!rstN)
    done && (faultCode == FC_INVALID) |-> resultEntry[1:0] == ET_INVALID);

  // R7: a depth fault is only reported at the last level
  p_depth_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    done && (faultCode == FC_DEPTH) |-> resultLevel == 2'd3);

endmodule

// File: tb/walk_unit_tb_top.sv
module walk_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [31:0] ptr;
    logic [15:0] ctx;
    logic [31:0] va;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [31:0] e2;
    logic [31:0] e3;
    logic        stall;
    logic        poke;
  } walkVec_t;

  localparam int NVEC = 7;
  localparam walkVec_t VECS [NVEC] = '{
    // leaf at context level
    '{32'h0012_3450, 16'h0005, 32'h1234_5678, 32'h1234_56AE, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0},
    // full descent to a level-3 leaf, with stalls and a start raised mid-walk
    '{32'h0000_0800, 16'h0003, 32'hC3A5_F123, 32'h0000_1001, 32'h0000_2001, 32'h0000_3001, 32'hABCD_E0A2, 1'b1, 1'b1},
    // invalid word at level 2
    '{32'h0004_0000, 16'h0100, 32'h8040_3000, 32'h0000_5001, 32'h0000_6001, 32'h0000_0000, 32'h0, 1'b0, 1'b0},
    // pointer word at level 3
    '{32'h0000_0010, 16'h0000, 32'h00FF_F000, 32'h0000_7001, 32'h0000_8011, 32'h0000_9021, 32'h0000_4001, 1'b0, 1'b0},
    // reverse-order leaf at level 1
    '{32'h0020_0000, 16'h0042, 32'h7F00_0000, 32'h0001_0001, 32'h0F00_00BF, 32'h0, 32'h0, 1'b1, 1'b0},
    // invalid word at context level
    '{32'h0000_1230, 16'h0001, 32'h0000_0000, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0},
    // extreme fields, address wrap, leaf at level 2
    '{32'hFFFF_FFF0, 16'hFFFF, 32'hFFFF_FFFF, 32'hFFFF_FFF1, 32'hFFFF_FFF1, 32'h8765_4322, 32'h0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        startValid;
  logic [31:0] startVaddr;
  logic [31:0] ctxBasePtr;
  logic [15:0] ctxNum;
  logic        busy;
  logic        memReqValid;
  logic        memReqReady;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        done;
  logic [31:0] resultEntry;
  logic [1:0]  resultLevel;
  logic        fault;
  logic [1:0]  faultCode;

  int checkCount = 0;
  int errorCount = 0;
  bit finished   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  walk_unit dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .startVaddr  (startVaddr),
    .ctxBasePtr  (ctxBasePtr),
    .ctxNum      (ctxNum),
    .busy        (busy),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memReqAddr  (memReqAddr),
    .memRspValid (memRspValid),
    .memRspData  (memRspData),
    .done        (done),
    .resultEntry (resultEntry),
    .resultLevel (resultLevel),
    .fault       (fault),
    .faultCode   (faultCode)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      errorCount++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] entryOf(input walkVec_t v, input int k);
    case (k)
      0:       return v.e0;
      1:       return v.e1;
      2:       return v.e2;
      default: return v.e3;
    endcase
  endfunction

  function automatic logic [31:0] expAddr(input walkVec_t v, input int k, input logic [31:0] prev);
    logic [31:0] idx;
    if (k == 0) return ((v.ptr & 32'hFFFF_FFF0) << 4) + ({16'h0, v.ctx} << 2);
    case (k)
      1:       idx = {24'h0, v.va[31:24]};
      2:       idx = {26'h0, v.va[23:18]};
      default: idx = {26'h0, v.va[17:12]};
    endcase
    return ((prev & 32'hFFFF_FFF0) << 4) + (idx << 2);
  endfunction

  task automatic waitReq();
    int n = 0;
    while (!memReqValid && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runVec(input walkVec_t v);
    logic [31:0] ent, prev, ea;
    logic [1:0]  expFc;
    bit fin;
    chk(busy === 1'b0, "R2 idle before start (busy)", {31'h0, busy}, 32'h0);
    ctxBasePtr = v.ptr; ctxNum = v.ctx; startVaddr = v.va; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", {31'h0, busy}, 32'h1);
    chk(memReqValid === 1'b1, "R2 request after start", {31'h0, memReqValid}, 32'h1);
    fin = 1'b0;
    prev = '0;
    for (int k = 0; k < 4 && !fin; k++) begin
      waitReq();
      ea = expAddr(v, k, prev);
      if (k == 0) chk(memReqAddr === ea, "R3 root slot address", memReqAddr, ea);
      else        chk(memReqAddr === ea, "R4 child table address", memReqAddr, ea);
      if (v.stall) begin
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          chk(memReqValid === 1'b1 && memReqAddr === ea, "R9 request held while not ready", memReqAddr, ea);
        end
      end
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      chk(memReqValid === 1'b0, "R9 no request while response pending", {31'h0, memReqValid}, 32'h0);
      if (v.poke && k == 0) begin
        startValid = 1'b1; startVaddr = ~v.va;
        @(negedge clk);
        startValid = 1'b0; startVaddr = v.va;
        chk(busy === 1'b1 && memReqValid === 1'b0, "R2 start while busy ignored", {31'h0, busy}, 32'h1);
      end
      ent = entryOf(v, k);
      memRspValid = 1'b1; memRspData = ent;
      @(negedge clk);
      memRspValid = 1'b0; memRspData = '0;
      fin = (ent[1:0] != 2'd1) || (k == 3);
      if (fin) begin
        expFc = (ent[1:0] == 2'd0) ? 2'd1 : (ent[1:0] == 2'd1) ? 2'd2 : 2'd0;
        chk(done === 1'b1, "R8 done after final response", {31'h0, done}, 32'h1);
        chk(busy === 1'b0, "R8 busy low with done", {31'h0, busy}, 32'h0);
        chk(resultLevel === 2'(k), "R5 result level", {30'h0, resultLevel}, k);
        if (expFc == 2'd0) begin
          chk(resultEntry === ent, "R5 leaf entry returned", resultEntry, ent);
          chk(faultCode === 2'd0 && fault === 1'b0, "R5 no fault on leaf", {30'h0, faultCode}, 32'h0);
        end else if (expFc == 2'd1) begin
          chk(faultCode === 2'd1 && fault === 1'b1, "R6 invalid entry fault", {30'h0, faultCode}, 32'h1);
        end else begin
          chk(faultCode === 2'd2 && fault === 1'b1, "R7 pointer at last level fault", {30'h0, faultCode}, 32'h2);
          chk(resultLevel === 2'd3, "R7 depth fault level", {30'h0, resultLevel}, 32'h3);
        end
        @(negedge clk);
        chk(done === 1'b0, "R8 done lasts one cycle", {31'h0, done}, 32'h0);
        chk(memReqValid === 1'b0, "R7 no read after walk end", {31'h0, memReqValid}, 32'h0);
      end
      prev = ent;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errorCount++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checkCount, errorCount);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; startValid = 1'b0; startVaddr = '0; ctxBasePtr = '0; ctxNum = '0;
    memReqReady = 1'b0; memRspValid = 1'b0; memRspData = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && memReqValid === 1'b0, "R1 reset state",
        {29'h0, busy, done, memReqValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R1: reset in the middle of a walk
    ctxBasePtr = 32'h0000_0100; ctxNum = 16'h0002; startVaddr = 32'h1111_1000; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    chk(memReqValid === 1'b1, "R1 walk running before reset", {31'h0, memReqValid}, 32'h1);
    rstN = 1'b0;
    #1;
    chk(busy === 1'b0 && memReqValid === 1'b0 && done === 1'b0, "R1 mid-walk reset clears",
        {29'h0, busy, done, memReqValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    runVec(VECS[1]);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checkCount, errorCount);
    $finish;
  end

endmodule